// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block produces the word-address sequence for one channel of a two-dimensional DMA transfer. Software-side logic hands it a start word address, a line length in words, a line stride in words (line length plus the gap between lines) and a line count minus one, then pulses start. The generator offers one word address at a time through a valid/ready handshake. It moves to the next address only when the consumer accepts the current one. In this normal mode it walks every word of every line, jumps by the stride at each line end, pulses a done event after the final word and goes idle.

A zero line length with the loop-arm input high selects an endless circular mode. In that mode the address climbs by one word per accepted beat across a region of stride*(count+1) words, then wraps back to the start address. The region is treated as two equal halves, and an event pulses when each half is finished, with a flag saying which half it was. A stop pulse aborts either mode at once. Memory access, data movement and register decoding are outside this block.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no start, valid_o, done_o and half_evt_o are all 0.
- R2: A start pulse while idle, with line_len_i nonzero, raises valid_o on the next cycle with addr_o equal to base_addr_i.
- R3: Within a line, addr_o rises by one for each beat where valid_o and ready_i are both 1. While ready_i is 0, addr_o and valid_o hold their values.
- R4: The first word of each following line sits at the previous line's first word plus line_stride_i.
- R5: line_cnt_i holds the number of lines minus one. A normal run accepts exactly line_len_i*(line_cnt_i+1) beats, and its last address is base + line_cnt_i*stride + line_len_i-1.
- R6: done_o is 1 for exactly one cycle: the cycle after the last beat is accepted. valid_o is 0 in that cycle.
- R7: A start pulse while valid_o is 1 is ignored. The address sequence continues unchanged.
- R8: A stop pulse makes valid_o 0 on the next cycle, and no done_o pulse follows.
- R9: With line_len_i equal to 0 and loop_arm_i equal to 1, start enters loop mode. The address for accepted beat k is base + (k mod R), where R = stride*(count+1), and the run never ends on its own.
- R10: In loop mode, half_evt_o pulses for one cycle after the beat at offset R/2-1, with half_sel_o equal to 0. It pulses again after the beat at offset R-1, with half_sel_o equal to 1. This repeats on every lap.
- R11: A start pulse with line_len_i equal to 0 and loop_arm_i equal to 0 is ignored, and valid_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; configuration is sampled with it |
| stop_i | input | 1 | Abort pulse |
| base_addr_i | input | 30 | Start word address |
| line_len_i | input | 16 | Words per line; 0 selects loop mode when armed |
| line_stride_i | input | 16 | Words from one line start to the next |
| line_cnt_i | input | 16 | Number of lines minus one |
| loop_arm_i | input | 1 | Allows loop mode when line length is 0 |
| ready_i | input | 1 | Consumer accepts the current address |
| valid_o | output | 1 | An address is offered |
| addr_o | output | 30 | Current word address |
| done_o | output | 1 | One-cycle pulse at the end of a normal run |
| half_evt_o | output | 1 | One-cycle pulse at the end of a loop-buffer half |
| half_sel_o | output | 1 | Which half just finished: 0 first, 1 second |

## Verification
The assertions assume that start_i and stop_i are single-cycle pulses. They also assume that loop mode is only entered with a region stride*(count+1) that is even and at least 2, so that both half boundaries exist. The bench keeps to this: it raises each control pulse for one cycle from a falling edge, and its only loop test uses a stride of 4 and two lines, which gives an eight-word region. In normal runs, ready is dropped on a different pattern for each table entry, so stalls fall both inside lines and at line ends.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    GEN_IDLE = 2'd0,
    GEN_LINE = 2'd1,
    GEN_RING = 2'd2
  } gen_state_e;

endpackage

// File: rtl/dma2d_seq.sv
module dma2d_seq
  import dma2d_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [LEN_W-1:0] line_len_i,
  input  logic             loop_arm_i,
  input  logic             beat_i,
  input  logic             line_end_i,
  output gen_state_e       state_o,
  output logic             load_o,
  output logic             done_o
);

  gen_state_e state_q, state_n;
  logic       done_q, done_n;
  logic       len_zero;

  assign len_zero = (line_len_i == '0);
  assign load_o   = (state_q == GEN_IDLE) && start_i && !stop_i &&
                    (!len_zero || loop_arm_i);

  always_comb begin
    state_n = state_q;
    done_n  = 1'b0;
    unique case (state_q)
      GEN_IDLE: begin
        if (load_o) state_n = len_zero ? GEN_RING : GEN_LINE;
      end
      GEN_LINE: begin
        if (stop_i) begin
          state_n = GEN_IDLE;
        end else if (beat_i && line_end_i) begin
          state_n = GEN_IDLE;
          done_n  = 1'b1;
        end
      end
      GEN_RING: begin
        if (stop_i) state_n = GEN_IDLE;
      end
      default: state_n = GEN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GEN_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

endmodule

// File: rtl/dma2d_line_walk.sv
module dma2d_line_walk #(
  parameter int AW    = 30,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [AW-1:0]    base_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] stride_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [AW-1:0]    addr_o,
  output logic             last_o
);

  logic [AW-1:0]    lbase_q, lbase_n;
  logic [LEN_W-1:0] col_q, col_n;
  logic [CNT_W-1:0] row_q, row_n;
  logic [LEN_W-1:0] len_q, stride_q;
  logic [CNT_W-1:0] cnt_q;
  logic             col_end;

  assign col_end = (col_q == len_q - LEN_W'(1));
  assign last_o  = col_end && (row_q == cnt_q);
  assign addr_o  = lbase_q + AW'(col_q);

  always_comb begin
    lbase_n = lbase_q;
    col_n   = col_q;
    row_n   = row_q;
    if (load_i) begin
      lbase_n = base_i;
      col_n   = '0;
      row_n   = '0;
    end else if (adv_i) begin
      if (col_end) begin
        col_n   = '0;
        row_n   = row_q + CNT_W'(1);
        lbase_n = lbase_q + AW'(stride_q);
      end else begin
        col_n = col_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbase_q <= '0;
      col_q   <= '0;
      row_q   <= '0;
    end else begin
      lbase_q <= lbase_n;
      col_q   <= col_n;
      row_q   <= row_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      stride_q <= '0;
      cnt_q    <= '0;
    end else if (load_i) begin
      len_q    <= len_i;
      stride_q <= stride_i;
      cnt_q    <= cnt_i;
    end
  end

endmodule

// File: rtl/dma2d_ring_walk.sv
module dma2d_ring_walk #(
  parameter int AW    = 30,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [AW-1:0]    base_i,
  input  logic [LEN_W-1:0] stride_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [AW-1:0]    addr_o,
  output logic             evt_o,
  output logic             sel_o
);

  localparam int OW = LEN_W + CNT_W + 1;

  logic [AW-1:0] base_q;
  logic [OW-1:0] off_q, off_n;
  logic [OW-1:0] half_q, end_q;
  logic [OW-1:0] region;
  logic          evt_q, evt_n, sel_q, sel_n;

  assign region = OW'(stride_i) * (OW'(cnt_i) + OW'(1));

  always_comb begin
    off_n = off_q;
    evt_n = 1'b0;
    sel_n = sel_q;
    if (load_i) begin
      off_n = '0;
      sel_n = 1'b0;
    end else if (adv_i) begin
      if (off_q == end_q) begin
        off_n = '0;
        evt_n = 1'b1;
        sel_n = 1'b1;
      end else begin
        off_n = off_q + OW'(1);
        if (off_q == half_q) begin
          evt_n = 1'b1;
          sel_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      evt_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      off_q <= off_n;
      evt_q <= evt_n;
      sel_q <= sel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      half_q <= '0;
      end_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      half_q <= (region >> 1) - OW'(1);
      end_q  <= region - OW'(1);
    end
  end

  assign addr_o = base_q + AW'(off_q);
  assign evt_o  = evt_q;
  assign sel_o  = sel_q;

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW    = 30,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [AW-1:0]    base_addr_i,
  input  logic [LEN_W-1:0] line_len_i,
  input  logic [LEN_W-1:0] line_stride_i,
  input  logic [CNT_W-1:0] line_cnt_i,
  input  logic             loop_arm_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [AW-1:0]    addr_o,
  output logic             done_o,
  output logic             half_evt_o,
  output logic             half_sel_o
);

  gen_state_e    state;
  logic          load, beat, line_adv, ring_adv, line_last;
  logic [AW-1:0] line_addr, ring_addr;

  assign valid_o  = (state != GEN_IDLE);
  assign beat     = valid_o && ready_i;
  assign line_adv = beat && !stop_i && (state == GEN_LINE);
  assign ring_adv = beat && !stop_i && (state == GEN_RING);
  assign addr_o   = (state == GEN_RING) ? ring_addr : line_addr;

  dma2d_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .line_len_i (line_len_i),
    .loop_arm_i (loop_arm_i),
    .beat_i     (beat),
    .line_end_i (line_last),
    .state_o    (state),
    .load_o     (load),
    .done_o     (done_o)
  );

  dma2d_line_walk #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .adv_i    (line_adv),
    .base_i   (base_addr_i),
    .len_i    (line_len_i),
    .stride_i (line_stride_i),
    .cnt_i    (line_cnt_i),
    .addr_o   (line_addr),
    .last_o   (line_last)
  );

  dma2d_ring_walk #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .adv_i    (ring_adv),
    .base_i   (base_addr_i),
    .stride_i (line_stride_i),
    .cnt_i    (line_cnt_i),
    .addr_o   (ring_addr),
    .evt_o    (half_evt_o),
    .sel_o    (half_sel_o)
  );

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW    = 30,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic [AW-1:0]    base_addr_i,
  input logic [LEN_W-1:0] line_len_i,
  input logic             loop_arm_i,
  input logic             ready_i,
  input logic             valid_o,
  input logic [AW-1:0]    addr_o,
  input logic             done_o,
  input logic             half_evt_o
);

  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_o && !stop_i && (line_len_i != '0 || loop_arm_i))
      |=> (valid_o && addr_o == $past(base_addr_i)));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !stop_i) |=> (valid_o && $stable(addr_o)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!valid_o && $past(valid_o && ready_i)));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && start_i && !ready_i && !stop_i) |=> $stable(addr_o));

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!valid_o && !done_o));

  // R10
  half_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_evt_o |-> (!done_o && $past(valid_o && ready_i)));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_o && line_len_i == '0 && !loop_arm_i) |=> !valid_o);

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .base_addr_i (base_addr_i),
  .line_len_i  (line_len_i),
  .loop_arm_i  (loop_arm_i),
  .ready_i     (ready_i),
  .valid_o     (valid_o),
  .addr_o      (addr_o),
  .done_o      (done_o),
  .half_evt_o  (half_evt_o)
);

// File: tb/test_dma2d_addr_gen.sv
`timescale 1ns/1ps
module test_dma2d_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, stop_i, loop_arm_i, ready_i;
  logic [29:0] base_addr_i;
  logic [15:0] line_len_i, line_stride_i, line_cnt_i;
  logic        valid_o, done_o, half_evt_o, half_sel_o;
  logic [29:0] addr_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  dma2d_addr_gen i_dma2d_addr_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .base_addr_i(base_addr_i), .line_len_i(line_len_i),
    .line_stride_i(line_stride_i), .line_cnt_i(line_cnt_i),
    .loop_arm_i(loop_arm_i), .ready_i(ready_i), .valid_o(valid_o),
    .addr_o(addr_o), .done_o(done_o), .half_evt_o(half_evt_o),
    .half_sel_o(half_sel_o)
  );

  localparam int NV = 4;
  localparam int V_BASE  [NV] = '{100, 500, 40, 1000};
  localparam int V_LEN   [NV] = '{4, 1, 3, 5};
  localparam int V_STR   [NV] = '{6, 1, 3, 10};
  localparam int V_CNT   [NV] = '{2, 0, 3, 1};
  localparam int V_BEATS [NV] = '{12, 1, 12, 10};
  localparam int V_LAST  [NV] = '{115, 500, 51, 1014};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic run_vec(input int i);
    int beats = 0, col = 0, row = 0, cyc = 0, last = -1, exp;
    bit rdy;
    base_addr_i = 30'(V_BASE[i]); line_len_i = 16'(V_LEN[i]);
    line_stride_i = 16'(V_STR[i]); line_cnt_i = 16'(V_CNT[i]);
    loop_arm_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(valid_o && addr_o == 30'(V_BASE[i]), "R2", int'(addr_o), V_BASE[i]);
    while (beats < V_BEATS[i] && cyc < 2000) begin
      rdy = ((cyc % (i + 2)) != 0);
      ready_i = rdy;
      if (rdy) begin
        exp = V_BASE[i] + row * V_STR[i] + col;
        if (col == 0 && row > 0)
          chk(valid_o && int'(addr_o) == exp, "R4", int'(addr_o), exp);
        else
          chk(valid_o && int'(addr_o) == exp, "R3", int'(addr_o), exp);
        last = int'(addr_o);
        beats++; col++;
        if (col == V_LEN[i]) begin col = 0; row++; end
      end
      @(negedge clk); cyc++;
    end
    ready_i = 1'b0;
    chk(done_o == 1'b1, "R6", int'(done_o), 1);
    chk(valid_o == 1'b0, "R6", int'(valid_o), 0);
    chk(last == V_LAST[i], "R5", last, V_LAST[i]);
    @(negedge clk);
    chk(done_o == 1'b0, "R6", int'(done_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int prev_off;
    bit have_prev, exp_evt;
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; loop_arm_i = 1'b0;
    ready_i = 1'b0; base_addr_i = '0; line_len_i = '0;
    line_stride_i = '0; line_cnt_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state while held and after release
    chk(!valid_o && !done_o && !half_evt_o, "R1", int'(valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!valid_o && !done_o && !half_evt_o, "R1", int'(valid_o), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R3 stall and R7 start while busy
    base_addr_i = 30'd300; line_len_i = 16'd4; line_stride_i = 16'd8;
    line_cnt_i = 16'd1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; ready_i = 1'b1;
    chk(addr_o == 30'd300, "R2", int'(addr_o), 300);
    @(negedge clk);
    chk(addr_o == 30'd301, "R3", int'(addr_o), 301);
    @(negedge clk); ready_i = 1'b0;
    base_addr_i = 30'd9000; line_len_i = 16'd2; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(valid_o && addr_o == 30'd302, "R7", int'(addr_o), 302);
    @(negedge clk);
    chk(valid_o && addr_o == 30'd302, "R3", int'(addr_o), 302);

    // R8 stop aborts with no done
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    chk(!valid_o && !done_o, "R8", int'(valid_o), 0);
    @(negedge clk);
    chk(!valid_o && !done_o, "R8", int'(done_o), 0);

    // R11 zero length without loop arm
    line_len_i = 16'd0; loop_arm_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(!valid_o, "R11", int'(valid_o), 0);
    @(negedge clk);
    chk(!valid_o && !done_o, "R11", int'(valid_o), 0);

    // R9 / R10 loop mode: stride 4, two lines, region 8
    base_addr_i = 30'd200; line_len_i = 16'd0; line_stride_i = 16'd4;
    line_cnt_i = 16'd1; loop_arm_i = 1'b1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    have_prev = 1'b0; prev_off = 0;
    for (int k = 0; k < 20; k++) begin
      if (have_prev) begin
        exp_evt = (prev_off == 3) || (prev_off == 7);
        chk(half_evt_o == exp_evt, "R10", int'(half_evt_o), int'(exp_evt));
        if (exp_evt)
          chk(half_sel_o == (prev_off == 7), "R10", int'(half_sel_o), int'(prev_off == 7));
      end
      ready_i = 1'b1;
      chk(valid_o && int'(addr_o) == 200 + (k % 8), "R9", int'(addr_o), 200 + (k % 8));
      prev_off = k % 8; have_prev = 1'b1;
      @(negedge clk);
    end
    ready_i = 1'b0; stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    chk(!valid_o, "R8", int'(valid_o), 0);
    loop_arm_i = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule